// File: doc/BRIEF.md
# Double-Data-Rate I/Q Bus Deinterleaver

This block takes one parallel sample bus that carries two channels in double-data-rate form and splits it into two channel outputs. The in-phase sample is taken on the rising edge of a data clock. The quadrature sample is taken on the falling edge that follows it. The block joins each I sample with the Q sample that came after it. It passes the pair through a fixed-length pipeline that ends in the converter clock domain, so both channel words change together on one converter clock edge.

The data clock runs at the per-channel sample rate, which makes the bus rate twice that rate. For example, a 200 MHz data clock carries 400 MSPS on the bus and 200 MSPS on each channel. The data clock and the converter clock have the same frequency and a fixed phase relationship, so the design needs no asynchronous FIFO. The two outputs can drive quadrature channels or two unrelated real channels. In both cases they share the same sample rate. A valid flag rises once the pipeline holds real data. Until then, and during reset, both outputs hold the midscale code.

Top module: `ddr_iq_deinterleave`

## Requirements
- R1: The bus word present at a rising edge of `dci_clk` is taken as the I sample. The word present at the next falling edge is taken as the Q sample of the same pair. I always comes first in a pair.
- R2: Both words of a pair appear on `chan_i` and `chan_q` after the same rising edge of `conv_clk`, and `chan_valid` is high at that point.
- R3: A pair whose I sample was taken on data-clock rising edge n is presented after converter-clock rising edge n+LATENCY. LATENCY defaults to 7.
- R4: Reset is released before rising edge 1. `chan_valid` stays low through rising edge LATENCY (7 by default) and goes high after rising edge LATENCY+1 (8 by default). This holds whatever the bus carries.
- R5: While `rst_n` is low, and at any time while `chan_valid` is low, both channel outputs hold midscale. Midscale is 16'h8000 for offset-binary samples (the default, SAMPLE_FMT = FMT_OFFSET_BIN) and 0 for two's-complement samples.
- R6: Once `chan_valid` is high, it stays high until the next reset. The pipeline advances on every clock, whether or not new data is arriving.
- R7: Each channel word is passed bit for bit, with no change. The two channels do not affect each other, and this includes the all-zero, all-one and midscale-neighbour codes.
- R8: Pairs sent on consecutive data-clock cycles come out on consecutive converter-clock cycles, in the same order, with none missing and none repeated.
- R9: Asserting `rst_n` low in the middle of a stream at once forces both outputs to midscale and `chan_valid` low. Pairs that were in flight are discarded, and after release the fill follows R4 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dci_clk | input | 1 | Data clock. I is captured on its rising edge and Q on its falling edge |
| conv_clk | input | 1 | Converter clock. Same frequency as `dci_clk`, fixed phase |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously |
| bus_data | input | SAMPLE_W | Shared sample bus carrying I and Q in double-data-rate form |
| chan_i | output | SAMPLE_W | I channel sample |
| chan_q | output | SAMPLE_W | Q channel sample |
| chan_valid | output | 1 | High once the pipeline has filled after reset |

## Verification
Each I sample is due on the outputs exactly LATENCY (7) converter rising edges after the data-clock rising edge that captured it, and its Q partner must appear on that same edge. The driver records the index of the capturing edge and queues the pair with a due index equal to that edge plus 7. The monitor samples at each falling edge and compares only when its edge counter reaches the due index, so a result that arrives one cycle early or late fails. After each reset release, the fill check expects `chan_valid` low and midscale outputs through edge 7, then valid high after edge 8. The check made when reset is asserted mid-stream looks one nanosecond after the reset edge.

// File: rtl/ddrdi_pkg.sv
package ddrdi_pkg;

  // Sample number format. It only decides which code counts as midscale.
  typedef enum logic {
    FMT_OFFSET_BIN = 1'b0,
    FMT_TWOS_COMP  = 1'b1
  } sample_fmt_e;

endpackage

// File: rtl/ddrdi_capture.sv
// Edge capture and pairing in the data clock domain.
// The rising edge captures I. The falling edge captures Q.
// The next rising edge registers the completed pair.
module ddrdi_capture #(
  parameter int                      SAMPLE_W   = 16,
  parameter ddrdi_pkg::sample_fmt_e  SAMPLE_FMT = ddrdi_pkg::FMT_OFFSET_BIN
) (
  input  logic                dci_clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] bus_data,
  output logic [SAMPLE_W-1:0] pair_i,
  output logic [SAMPLE_W-1:0] pair_q,
  output logic                pair_vld
);

  localparam logic [SAMPLE_W-1:0] MIDSCALE =
    (SAMPLE_FMT == ddrdi_pkg::FMT_OFFSET_BIN) ? {1'b1, {(SAMPLE_W-1){1'b0}}}
                                              : {SAMPLE_W{1'b0}};

  logic [SAMPLE_W-1:0] i_cap_q, i_cap_d;
  logic                i_vld_q, i_vld_d;
  logic [SAMPLE_W-1:0] q_cap_q, q_cap_d;
  logic                q_load_en;
  logic [SAMPLE_W-1:0] pair_i_q, pair_i_d;
  logic [SAMPLE_W-1:0] pair_q_q, pair_q_d;
  logic                pair_vld_q, pair_vld_d;

  // Rising-edge I capture. A new I word is taken on every cycle after reset.
  always_comb begin
    i_cap_d = bus_data;
    i_vld_d = 1'b1;
  end

  always_ff @(posedge dci_clk or negedge rst_n) begin
    if (!rst_n) begin
      i_cap_q <= MIDSCALE;
      i_vld_q <= 1'b0;
    end else begin
      i_cap_q <= i_cap_d;
      i_vld_q <= i_vld_d;
    end
  end

  // Falling-edge Q capture. It is enabled only after an I has been taken,
  // so the first pair cannot be a Q word with no I before it.
  always_comb begin
    q_load_en = i_vld_q;
    q_cap_d   = q_load_en ? bus_data : q_cap_q;
  end

  always_ff @(negedge dci_clk or negedge rst_n) begin
    if (!rst_n) q_cap_q <= MIDSCALE;
    else        q_cap_q <= q_cap_d;
  end

  // Pair register. I from the previous rising edge and Q from the falling edge after it.
  always_comb begin
    pair_i_d   = i_cap_q;
    pair_q_d   = q_cap_q;
    pair_vld_d = i_vld_q;
  end

  always_ff @(posedge dci_clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_i_q   <= MIDSCALE;
      pair_q_q   <= MIDSCALE;
      pair_vld_q <= 1'b0;
    end else begin
      pair_i_q   <= pair_i_d;
      pair_q_q   <= pair_q_d;
      pair_vld_q <= pair_vld_d;
    end
  end

  assign pair_i   = pair_i_q;
  assign pair_q   = pair_q_q;
  assign pair_vld = pair_vld_q;

  // Copies taken on the opposite edge, used to show each capture register
  // changes only on its own edge.
  logic [SAMPLE_W-1:0] i_seen_at_fall;
  logic [SAMPLE_W-1:0] q_seen_at_rise;

  always_ff @(negedge dci_clk or negedge rst_n) begin
    if (!rst_n) i_seen_at_fall <= MIDSCALE;
    else        i_seen_at_fall <= i_cap_q;
  end

  always_ff @(posedge dci_clk or negedge rst_n) begin
    if (!rst_n) q_seen_at_rise <= MIDSCALE;
    else        q_seen_at_rise <= q_cap_q;
  end

  // R1: the I register keeps its value across the falling edge.
  assert_i_rising_only_R1: assert property (@(posedge dci_clk) disable iff (!rst_n)
    i_cap_q == i_seen_at_fall)
    else $error("I capture register changed on a falling edge");

  // R1: the Q register keeps its value across the rising edge.
  assert_q_falling_only_R1: assert property (@(negedge dci_clk) disable iff (!rst_n)
    q_cap_q == q_seen_at_rise)
    else $error("Q capture register changed on a rising edge");

endmodule

// File: rtl/ddrdi_align.sv
// Fixed-length alignment pipeline in the converter clock domain.
// I, Q and valid move together through every stage.
module ddrdi_align #(
  parameter int                      SAMPLE_W   = 16,
  parameter int                      STAGES     = 6,
  parameter ddrdi_pkg::sample_fmt_e  SAMPLE_FMT = ddrdi_pkg::FMT_OFFSET_BIN
) (
  input  logic                conv_clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic                in_vld,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q,
  output logic                out_vld
);

  localparam logic [SAMPLE_W-1:0] MIDSCALE =
    (SAMPLE_FMT == ddrdi_pkg::FMT_OFFSET_BIN) ? {1'b1, {(SAMPLE_W-1){1'b0}}}
                                              : {SAMPLE_W{1'b0}};

  typedef struct packed {
    logic                vld;
    logic [SAMPLE_W-1:0] i;
    logic [SAMPLE_W-1:0] q;
  } lane_t;

  localparam lane_t LANE_RESET = '{vld: 1'b0, i: MIDSCALE, q: MIDSCALE};

  lane_t stage_q [STAGES];
  lane_t stage_d [STAGES];
  lane_t lane_in;

  assign lane_in = '{vld: in_vld, i: in_i, q: in_q};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_comb stage_d[s] = lane_in;
    end else begin : g_body
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge conv_clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= LANE_RESET;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign out_i   = stage_q[STAGES-1].i;
  assign out_q   = stage_q[STAGES-1].q;
  assign out_vld = stage_q[STAGES-1].vld;

  // R6: once valid has reached the output, it stays high until reset.
  assert_valid_sticky_R6: assert property (@(posedge conv_clk) disable iff (!rst_n)
    out_vld |=> out_vld)
    else $error("output valid dropped without reset");

endmodule

// File: rtl/ddr_iq_deinterleave.sv
// Top level: DDR I/Q bus capture, pairing and fixed-latency alignment.
module ddr_iq_deinterleave #(
  parameter int                      SAMPLE_W   = 16,
  parameter int                      LATENCY    = 7,
  parameter ddrdi_pkg::sample_fmt_e  SAMPLE_FMT = ddrdi_pkg::FMT_OFFSET_BIN
) (
  input  logic                dci_clk,
  input  logic                conv_clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] bus_data,
  output logic [SAMPLE_W-1:0] chan_i,
  output logic [SAMPLE_W-1:0] chan_q,
  output logic                chan_valid
);

  // The pair register in the data domain is one cycle of the latency.
  // The rest is made up by alignment stages.
  localparam int ALIGN_STAGES = LATENCY - 1;
  localparam logic [SAMPLE_W-1:0] MIDSCALE =
    (SAMPLE_FMT == ddrdi_pkg::FMT_OFFSET_BIN) ? {1'b1, {(SAMPLE_W-1){1'b0}}}
                                              : {SAMPLE_W{1'b0}};

  if (LATENCY < 2) begin : g_bad_latency
    $error("LATENCY must be at least 2");
  end

  logic [SAMPLE_W-1:0] pair_i, pair_q;
  logic                pair_vld;

  ddrdi_capture #(
    .SAMPLE_W   (SAMPLE_W),
    .SAMPLE_FMT (SAMPLE_FMT)
  ) u_capture (
    .dci_clk  (dci_clk),
    .rst_n    (rst_n),
    .bus_data (bus_data),
    .pair_i   (pair_i),
    .pair_q   (pair_q),
    .pair_vld (pair_vld)
  );

  ddrdi_align #(
    .SAMPLE_W   (SAMPLE_W),
    .STAGES     (ALIGN_STAGES),
    .SAMPLE_FMT (SAMPLE_FMT)
  ) u_align (
    .conv_clk (conv_clk),
    .rst_n    (rst_n),
    .in_i     (pair_i),
    .in_q     (pair_q),
    .in_vld   (pair_vld),
    .out_i    (chan_i),
    .out_q    (chan_q),
    .out_vld  (chan_valid)
  );

  // Separate fill counter: converter edges since reset release, saturating.
  localparam int FILL_MAX = LATENCY + 1;
  localparam int FILL_W   = $clog2(FILL_MAX + 1);
  localparam logic [FILL_W-1:0] FILL_TOP = FILL_W'(FILL_MAX);

  logic [FILL_W-1:0] fill_cnt_q, fill_cnt_d;

  always_comb begin
    fill_cnt_d = (fill_cnt_q == FILL_TOP) ? fill_cnt_q : fill_cnt_q + 1'b1;
  end

  always_ff @(posedge conv_clk or negedge rst_n) begin
    if (!rst_n) fill_cnt_q <= '0;
    else        fill_cnt_q <= fill_cnt_d;
  end

  // R4: valid rises after exactly LATENCY+1 converter edges following release.
  assert_fill_latency_R4: assert property (@(posedge conv_clk) disable iff (!rst_n)
    chan_valid == (fill_cnt_q == FILL_TOP))
    else $error("valid does not match pipeline fill time");

  // R5: outputs sit at midscale whenever valid is low.
  assert_idle_midscale_R5: assert property (@(posedge conv_clk) disable iff (!rst_n)
    !chan_valid |-> (chan_i == MIDSCALE && chan_q == MIDSCALE))
    else $error("output not at midscale while invalid");

endmodule

// File: tb/ddr_iq_deinterleave_tb.sv
module ddr_iq_deinterleave_tb;

  localparam int W   = 16;
  localparam int LAT = 7;
  localparam logic [W-1:0] MID = 16'h8000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] bus = '0;
  logic [W-1:0] chan_i, chan_q;
  logic         chan_valid;

  always #4 clk = ~clk;  // 125 MHz. Data and converter clocks share one phase.

  ddr_iq_deinterleave #(.SAMPLE_W(W), .LATENCY(LAT)) u_dut (
    .dci_clk    (clk),
    .conv_clk   (clk),
    .rst_n      (rst_n),
    .bus_data   (bus),
    .chan_i     (chan_i),
    .chan_q     (chan_q),
    .chan_valid (chan_valid)
  );

  typedef struct {
    logic [W-1:0] i;
    logic [W-1:0] q;
    int           due;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   fill_watch = 1'b0;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Driver: I is on the bus around the rising edge, Q around the falling edge.
  task automatic send_pair(input logic [W-1:0] i, input logic [W-1:0] q);
    exp_t e;
    @(negedge clk); #2;
    bus = i;
    @(posedge clk); #2;
    e.i = i; e.q = q; e.due = cyc + LAT;  // R3: due LAT edges after the I capture
    sb.push_back(e);
    bus = q;
  endtask

  // Monitor: samples at falling edges, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && fill_watch) begin
        if (cyc <= LAT + 1) begin
          check(chan_valid == (cyc == LAT + 1), "R4", "fill valid", chan_valid, cyc == LAT + 1);
          if (cyc <= LAT)
            check(chan_i == MID && chan_q == MID, "R5", "midscale before valid",
                  {chan_i, chan_q}, {MID, MID});
        end else fill_watch = 1'b0;
      end
      if (rst_n && sb.size() > 0) begin
        if (sb[0].due == cyc) begin
          check(chan_valid == 1'b1, "R3", "valid at due edge", chan_valid, 1);
          check(chan_i == sb[0].i, "R1", "I word", chan_i, sb[0].i);
          check(chan_q == sb[0].q, "R2", "Q word same edge", chan_q, sb[0].q);
          void'(sb.pop_front());
        end else if (sb[0].due < cyc) begin
          check(1'b0, "R8", "pair missed", cyc, sb[0].due);
          void'(sb.pop_front());
        end
      end
    end
  end

  task automatic drain();
    for (int k = 0; k < 40 && sb.size() > 0; k++) @(negedge clk);
    check(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    fill_watch = 1'b1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    // R5: outputs while reset is held
    repeat (3) @(negedge clk);
    check(chan_i == MID && chan_q == MID, "R5", "midscale in reset", {chan_i, chan_q}, {MID, MID});
    check(chan_valid == 1'b0, "R5", "valid low in reset", chan_valid, 0);

    release_reset();
    // R8: back-to-back stream of distinct pairs
    for (int k = 0; k < 24; k++) send_pair(W'(16'h0101 * k + 16'h0011), W'(16'hF00F - 16'h0203 * k));
    // R7: extreme and neighbouring codes on each channel
    send_pair(16'hFFFF, 16'h0000);
    send_pair(16'h0000, 16'hFFFF);
    send_pair(16'h8000, 16'h7FFF);
    send_pair(16'h7FFF, 16'h8000);
    send_pair(16'hA5A5, 16'hA5A5);
    drain();

    // R6: valid holds during a gap with garbage on the bus
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #2; bus = W'(16'h3C3C ^ (k * 16'h1111));
      check(chan_valid == 1'b1, "R6", "valid held in gap", chan_valid, 1);
    end
    for (int k = 0; k < 5; k++) send_pair(W'(16'h1234 + k), W'(16'h4321 - k));
    drain();

    // R9: reset asserted mid-stream
    for (int k = 0; k < 4; k++) send_pair(W'(16'h5550 + k), W'(16'h0AA0 + k));
    @(negedge clk); #1;
    rst_n = 1'b0;
    #1;
    check(chan_i == MID && chan_q == MID, "R9", "midscale on reset", {chan_i, chan_q}, {MID, MID});
    check(chan_valid == 1'b0, "R9", "valid cleared on reset", chan_valid, 0);
    sb.delete();
    repeat (2) @(negedge clk);
    check(chan_valid == 1'b0, "R9", "valid low while held", chan_valid, 0);
    release_reset();
    for (int k = 0; k < 10; k++) send_pair(W'(16'hC000 + 16'h0105 * k), W'(16'h0F0F + k));
    drain();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule